// File: doc/BRIEF.md
# Watchdog Lockup Recovery Sequencer

This block sits beside a hardware watchdog and decides what happens once that watchdog reports a lockup. A static configuration input picks one of two policies. Under the first policy, a lockup triggers a single automatic reboot. Under the second, the block never reboots and only reports. In both cases the block raises a sticky lockup status bit and issues status-message requests to a separate sender. Each request carries a sequence number and a flag that marks a watchdog event.

Under the reboot policy, firmware that comes back up after the reboot clears the status bit, and the block returns to idle. If the watchdog expires again before that happens, the block gives up rebooting. It then emits a heartbeat message once every heartbeat period. Heartbeats continue through forced power-off, power-button wake and externally requested resets. They stop only when firmware clears the status bit. The heartbeat period is counted in clock-enable ticks, so a bench can shrink the nominal half-minute interval to a few cycles.

Top module: `wdog_recovery_top`

## Requirements
- R1: After a synchronous reset, the following hold: lockup status 0, reboot request 0, power state working (`pwr_off` = 0), no message pending, and sequence number 0.
- R2: A watchdog timeout in the idle state sets the lockup status. The status stays set until firmware clears it with `fw_clear`.
- R3: Under the reboot policy (`cfg_reboot` = 1), the first timeout issues exactly one message with `msg_wd` = 1. It also raises `reboot_req` for exactly one cycle.
- R4: Under the reboot policy, a `fw_clear` after the reboot attempt clears the status and returns the block to idle. No heartbeat message follows, however many ticks arrive.
- R5: Under the reboot policy, a further timeout before any clear requests no reboot and sends no message. After that, one message with `msg_wd` = 0 is issued on every `HB_TICKS`-th tick.
- R6: Under the no-reboot policy (`cfg_reboot` = 0), a timeout issues one message with `msg_wd` = 1 and the next sequence number, and no reboot request. Heartbeats follow every `HB_TICKS` ticks.
- R7: `pwr_ovr` sets `pwr_off` to 1, and heartbeats continue. `pwr_btn` returns `pwr_off` to 0. `pwr_btn` while working has no effect.
- R8: In heartbeat mode, `ext_rst_req` produces one `reboot_req` pulse. Further requests are ignored until `rst_ok` reports success. `rst_ok` also returns the power state to working. Heartbeats continue in all cases.
- R9: `fw_clear` in heartbeat mode clears the status and stops all later heartbeats.
- R10: The sequence number is 8 bits. It increases by one for each newly raised request, and wraps from 255 to 0.
- R11: A request stays high until `msg_ack`. A heartbeat that falls due while a request is pending merges into it: the sequence number stays the same and the request stays held.
- R12: A timeout in heartbeat mode has no effect: no message and no reboot request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_reboot | input | 1 | 1 = one automatic reboot on lockup, 0 = never reboot |
| tick_en | input | 1 | Heartbeat time-base tick (one cycle per tick) |
| wd_timeout | input | 1 | Watchdog expiry pulse |
| fw_clear | input | 1 | Firmware strobe that clears the lockup status |
| pwr_btn | input | 1 | Power-button press event |
| pwr_ovr | input | 1 | Power-button override event |
| ext_rst_req | input | 1 | External reset request |
| rst_ok | input | 1 | Reset-attempt success indication |
| msg_ack | input | 1 | Sender has taken the pending message |
| lock_sts | output | 1 | Sticky lockup status |
| reboot_req | output | 1 | One-cycle reboot/reset request |
| pwr_off | output | 1 | Power state: 0 working, 1 soft-off |
| msg_req | output | 1 | Message request, held until acknowledged |
| msg_seq | output | 8 | Sequence number of the pending message |
| msg_wd | output | 1 | Message reports a watchdog event |

## Verification
Every result is registered once. A stimulus applied in one cycle therefore shows up on `lock_sts`, `reboot_req`, `pwr_off` and the message outputs just after the next rising edge. For a heartbeat, that edge is the one that samples the `HB_TICKS`-th tick since heartbeat mode began or since the previous heartbeat. The bench drives each input one time unit after a rising edge and holds it across exactly one edge. It reads the outputs one time unit after that edge, which is the first point where the new value is due. A one-cycle pulse is checked again one edge later to confirm it has dropped. Absence checks (no heartbeat after a clear, no reboot on a late timeout) are taken after enough ticks for a message to have been due.

// File: rtl/wrec_pkg.sv
package wrec_pkg;

    localparam int SEQ_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BEAT  = 2'd2
    } wrec_state_e;

    typedef struct packed {
        logic valid;
        logic wd;
    } msg_evt_t;

    function automatic logic [SEQ_W-1:0] seq_next(input logic [SEQ_W-1:0] s);
        return s + {{(SEQ_W-1){1'b0}}, 1'b1};
    endfunction

    function automatic msg_evt_t evt_merge(input msg_evt_t a, input msg_evt_t b);
        msg_evt_t r;
        r.valid = a.valid | b.valid;
        r.wd    = (a.valid & a.wd) | (b.valid & b.wd);
        return r;
    endfunction

endpackage

// File: rtl/wrec_policy_fsm.sv
module wrec_policy_fsm
    import wrec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_reboot,
    input  logic        wd_timeout,
    input  logic        fw_clear,
    input  logic        pwr_btn,
    input  logic        pwr_ovr,
    input  logic        ext_rst_req,
    input  logic        rst_ok,
    output wrec_state_e state_o,
    output logic        sts_o,
    output logic        reboot_o,
    output logic        pwr_off_o,
    output msg_evt_t    lock_evt_o
);

    wrec_state_e st_q, st_n;
    logic        sts_q, sts_n;
    logic        pend_q, pend_n;
    logic        pwr_q, pwr_n;
    logic        reboot_q, reboot_n;

    always_comb begin
        st_n       = st_q;
        sts_n      = sts_q;
        pend_n     = pend_q;
        reboot_n   = 1'b0;
        lock_evt_o = '0;

        // an outstanding attempt that reports success puts the system back to work
        if (pend_q && rst_ok && st_q != ST_IDLE) begin
            pend_n = 1'b0;
        end

        if (pwr_ovr) begin
            pwr_n = 1'b1;
        end else if (pwr_btn || (pend_q && rst_ok)) begin
            pwr_n = 1'b0;
        end else begin
            pwr_n = pwr_q;
        end

        unique case (st_q)
            ST_IDLE: begin
                if (wd_timeout) begin
                    sts_n            = 1'b1;
                    lock_evt_o.valid = 1'b1;
                    lock_evt_o.wd    = 1'b1;
                    if (cfg_reboot) begin
                        reboot_n = 1'b1;
                        pend_n   = 1'b1;
                        st_n     = ST_ARMED;
                    end else begin
                        st_n = ST_BEAT;
                    end
                end
            end
            ST_ARMED: begin
                if (fw_clear) begin
                    sts_n  = 1'b0;
                    pend_n = 1'b0;
                    st_n   = ST_IDLE;
                end else if (wd_timeout) begin
                    pend_n = 1'b0;
                    st_n   = ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (fw_clear) begin
                    sts_n  = 1'b0;
                    pend_n = 1'b0;
                    st_n   = ST_IDLE;
                end else if (ext_rst_req && !pend_q) begin
                    reboot_n = 1'b1;
                    pend_n   = 1'b1;
                end
            end
            default: begin
                st_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            sts_q    <= 1'b0;
            pend_q   <= 1'b0;
            pwr_q    <= 1'b0;
            reboot_q <= 1'b0;
        end else begin
            st_q     <= st_n;
            sts_q    <= sts_n;
            pend_q   <= pend_n;
            pwr_q    <= pwr_n;
            reboot_q <= reboot_n;
        end
    end

    assign state_o   = st_q;
    assign sts_o     = sts_q;
    assign reboot_o  = reboot_q;
    assign pwr_off_o = pwr_q;

endmodule

// File: rtl/wrec_beat_timer.sv
module wrec_beat_timer #(
    parameter int HB_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick_en,
    output logic fire_o
);

    localparam int CW = (HB_TICKS > 1) ? $clog2(HB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HB_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign fire_o = run && tick_en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/wrec_msg_port.sv
module wrec_msg_port
    import wrec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  msg_evt_t         evt,
    input  logic             ack,
    output logic             req_o,
    output logic [SEQ_W-1:0] seq_o,
    output logic             wd_o
);

    logic             req_q;
    logic [SEQ_W-1:0] seq_q;
    logic             wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            seq_q <= '0;
            wd_q  <= 1'b0;
        end else if (!req_q || ack) begin
            // slot free (or freed this cycle): a new event opens a fresh request
            req_q <= evt.valid;
            if (evt.valid) begin
                seq_q <= seq_next(seq_q);
                wd_q  <= evt.wd;
            end
        end else if (evt.valid) begin
            // merge into the pending request
            wd_q <= wd_q | evt.wd;
        end
    end

    assign req_o = req_q;
    assign seq_o = seq_q;
    assign wd_o  = wd_q;

endmodule

// File: rtl/wdog_recovery_top.sv
module wdog_recovery_top
    import wrec_pkg::*;
#(
    parameter int HB_TICKS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_reboot,
    input  logic             tick_en,
    input  logic             wd_timeout,
    input  logic             fw_clear,
    input  logic             pwr_btn,
    input  logic             pwr_ovr,
    input  logic             ext_rst_req,
    input  logic             rst_ok,
    input  logic             msg_ack,
    output logic             lock_sts,
    output logic             reboot_req,
    output logic             pwr_off,
    output logic             msg_req,
    output logic [SEQ_W-1:0] msg_seq,
    output logic             msg_wd
);

    wrec_state_e state;
    msg_evt_t    lock_evt;
    msg_evt_t    beat_evt;
    logic        beat_fire;

    wrec_policy_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg_reboot  (cfg_reboot),
        .wd_timeout  (wd_timeout),
        .fw_clear    (fw_clear),
        .pwr_btn     (pwr_btn),
        .pwr_ovr     (pwr_ovr),
        .ext_rst_req (ext_rst_req),
        .rst_ok      (rst_ok),
        .state_o     (state),
        .sts_o       (lock_sts),
        .reboot_o    (reboot_req),
        .pwr_off_o   (pwr_off),
        .lock_evt_o  (lock_evt)
    );

    wrec_beat_timer #(.HB_TICKS(HB_TICKS)) u_beat (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_BEAT),
        .tick_en (tick_en),
        .fire_o  (beat_fire)
    );

    assign beat_evt.valid = beat_fire;
    assign beat_evt.wd    = 1'b0;

    wrec_msg_port u_msg (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt_merge(lock_evt, beat_evt)),
        .ack   (msg_ack),
        .req_o (msg_req),
        .seq_o (msg_seq),
        .wd_o  (msg_wd)
    );

endmodule

// File: rtl/wrec_checker.sv
module wrec_checker
    import wrec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_reboot,
    input logic             tick_en,
    input logic             wd_timeout,
    input logic             fw_clear,
    input logic             pwr_btn,
    input logic             pwr_ovr,
    input logic             ext_rst_req,
    input logic             rst_ok,
    input logic             msg_ack,
    input logic             lock_sts,
    input logic             reboot_req,
    input logic             pwr_off,
    input logic             msg_req,
    input logic [SEQ_W-1:0] msg_seq,
    input logic             msg_wd
);

    assert_sts_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        lock_sts && !fw_clear |=> lock_sts);

    assert_reboot_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        reboot_req |=> !reboot_req);

    assert_reboot_needs_sts_R8: assert property (@(posedge clk) disable iff (rst)
        reboot_req |-> lock_sts);

    assert_soft_off_cause_R7: assert property (@(posedge clk) disable iff (rst)
        !pwr_off && !pwr_ovr |=> !pwr_off);

    assert_req_held_R11: assert property (@(posedge clk) disable iff (rst)
        msg_req && !msg_ack |=> msg_req && $stable(msg_seq));

    assert_seq_step_R10: assert property (@(posedge clk) disable iff (rst)
        !msg_req |=> (!msg_req && $stable(msg_seq)) || msg_seq == $past(msg_seq) + 8'd1);

endmodule

bind wdog_recovery_top wrec_checker u_chk (.*);

// File: tb/tb_wdog_recovery_top.sv
module tb_wdog_recovery_top;

    localparam int HB = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_reboot = 1'b1;
    logic       tick_en = 1'b0;
    logic       wd_timeout = 1'b0;
    logic       fw_clear = 1'b0;
    logic       pwr_btn = 1'b0;
    logic       pwr_ovr = 1'b0;
    logic       ext_rst_req = 1'b0;
    logic       rst_ok = 1'b0;
    logic       msg_ack = 1'b0;
    logic       lock_sts, reboot_req, pwr_off, msg_req, msg_wd;
    logic [7:0] msg_seq;

    int n_chk = 0;
    int n_fail = 0;
    int exp_seq = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_recovery_top #(.HB_TICKS(HB)) dut (
        .clk(clk), .rst(rst), .cfg_reboot(cfg_reboot), .tick_en(tick_en),
        .wd_timeout(wd_timeout), .fw_clear(fw_clear), .pwr_btn(pwr_btn),
        .pwr_ovr(pwr_ovr), .ext_rst_req(ext_rst_req), .rst_ok(rst_ok),
        .msg_ack(msg_ack), .lock_sts(lock_sts), .reboot_req(reboot_req),
        .pwr_off(pwr_off), .msg_req(msg_req), .msg_seq(msg_seq), .msg_wd(msg_wd)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wd_pulse();   wd_timeout = 1; step(); wd_timeout = 0; endtask
    task automatic clear_pulse(); fw_clear = 1; step(); fw_clear = 0; endtask
    task automatic ack_pulse();  msg_ack = 1; step(); msg_ack = 0; endtask
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick_en = 1; step(); tick_en = 0; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 sts", lock_sts, 0);
        chk("R1 reboot", reboot_req, 0);
        chk("R1 pwr", pwr_off, 0);
        chk("R1 req", msg_req, 0);
        chk("R1 seq", msg_seq, 0);

        // reboot policy, first lockup
        cfg_reboot = 1;
        wd_pulse();
        exp_seq++;
        chk("R2 sts set", lock_sts, 1);
        chk("R3 reboot", reboot_req, 1);
        chk("R3 msg", msg_req, 1);
        chk("R3 wd flag", msg_wd, 1);
        chk("R10 seq", msg_seq, exp_seq);
        step();
        chk("R3 reboot one cycle", reboot_req, 0);
        ack_pulse();
        chk("R11 released", msg_req, 0);
        ticks(HB + 2);
        chk("R3 single msg", msg_req, 0);
        chk("R2 still set", lock_sts, 1);
        clear_pulse();
        chk("R4 sts cleared", lock_sts, 0);
        ticks(2 * HB);
        chk("R4 no heartbeat", msg_req, 0);

        // reboot policy, reboot fails: third timeout
        wd_pulse();
        exp_seq++;
        chk("R3 second lockup seq", msg_seq, exp_seq);
        ack_pulse();
        wd_pulse();
        chk("R5 no reboot", reboot_req, 0);
        chk("R5 no msg", msg_req, 0);
        chk("R5 sts", lock_sts, 1);
        ticks(HB - 1);
        chk("R5 not yet", msg_req, 0);
        ticks(1);
        exp_seq++;
        chk("R5 heartbeat", msg_req, 1);
        chk("R5 hb wd flag", msg_wd, 0);
        chk("R10 hb seq", msg_seq, exp_seq);
        ack_pulse();

        // R12 timeout in heartbeat mode
        wd_pulse();
        chk("R12 no msg", msg_req, 0);
        chk("R12 no reboot", reboot_req, 0);

        // R11 merge
        ticks(HB);
        exp_seq++;
        chk("R11 req", msg_req, 1);
        ticks(HB);
        chk("R11 merged held", msg_req, 1);
        chk("R11 merged seq", msg_seq, exp_seq);
        ack_pulse();
        chk("R11 ack", msg_req, 0);

        // R7 power events
        pwr_btn = 1; step(); pwr_btn = 0;
        chk("R7 btn while working", pwr_off, 0);
        pwr_ovr = 1; step(); pwr_ovr = 0;
        chk("R7 override", pwr_off, 1);
        ticks(HB);
        exp_seq++;
        chk("R7 hb in soft-off", msg_req, 1);
        chk("R7 hb seq", msg_seq, exp_seq);
        ack_pulse();
        pwr_btn = 1; step(); pwr_btn = 0;
        chk("R7 wake", pwr_off, 0);

        // R8 external reset attempts
        pwr_ovr = 1; step(); pwr_ovr = 0;
        ext_rst_req = 1; step(); ext_rst_req = 0;
        chk("R8 reset attempt", reboot_req, 1);
        step();
        chk("R8 one pulse", reboot_req, 0);
        ext_rst_req = 1; step(); ext_rst_req = 0;
        chk("R8 ignored while pending", reboot_req, 0);
        rst_ok = 1; step(); rst_ok = 0;
        chk("R8 success wakes", pwr_off, 0);
        ext_rst_req = 1; step(); ext_rst_req = 0;
        chk("R8 new attempt", reboot_req, 1);
        ticks(HB);
        exp_seq++;
        chk("R8 hb continue", msg_req, 1);
        chk("R8 hb seq", msg_seq, exp_seq);
        ack_pulse();

        // R9 clear in heartbeat mode
        clear_pulse();
        chk("R9 sts", lock_sts, 0);
        ticks(3 * HB);
        chk("R9 no heartbeat", msg_req, 0);

        // R6 no-reboot policy
        cfg_reboot = 0;
        wd_pulse();
        exp_seq++;
        chk("R6 msg", msg_req, 1);
        chk("R6 wd flag", msg_wd, 1);
        chk("R6 seq", msg_seq, exp_seq);
        chk("R6 no reboot", reboot_req, 0);
        chk("R6 sts", lock_sts, 1);
        ack_pulse();
        ticks(HB);
        exp_seq++;
        chk("R6 heartbeat", msg_req, 1);
        chk("R6 hb flag", msg_wd, 0);
        ack_pulse();

        // R10 sweep through wrap
        while (exp_seq < 258) begin
            ticks(HB);
            exp_seq++;
            chk("R10 sweep req", msg_req, 1);
            chk("R10 sweep seq", msg_seq, exp_seq % 256);
            ack_pulse();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule